// File: doc/BRIEF.md
# Multi-Source Reset Merger with Early Request

This block folds several reset sources into a single reset for one clock domain. Each source may be active-high or active-low, chosen per bit at build time. The merged condition drives the output reset through one of three conditioning styles. In the first the condition passes straight through. In the second assertion is immediate and release is aligned to the clock. In the third both edges are aligned to the clock.

The block can also produce a reset request. This warning signal rises ahead of the reset, so that on-chip memories and similar state can stop accepting addresses or clock enables before reset lands. Once raised, the request stays high until the reset has been applied and fully released. Even a short disturbance on an input therefore runs to a complete, ordered reset sequence. Output reset and request leave the block together on the same release edge.

Top module: `rst_bridge`

## Requirements
- R1: Input bit i is active-low when bit i of `LOW_MASK` is 1 (active level 0) and active-high otherwise. The merged condition is true while any input sits at its active level.
- R2: With `MODE` = 0 (pass-through), `rst_out` follows the merged condition with no clock edge needed, and `rst_req` equals `rst_out`.
- R3: With `MODE` = 1 and `REQ_EN` = 0, `rst_out` rises together with the merged condition without waiting for a clock edge, and `rst_req` stays 0.
- R4: With `MODE` = 1 and `REQ_EN` = 1, `rst_req` rises together with the merged condition without a clock edge. `rst_out` rises on the second rising edge after that.
- R5: With `MODE` = 2, the merged condition is sampled on rising edges. If it is seen at edge k, `rst_req` rises after edge k+1 and `rst_out` after edge k+3.
- R6: In modes 1 and 2, `rst_out` falls on the second rising edge after the merged condition goes false, provided it stays false.
- R7: On release, `rst_req` falls on the same edge as `rst_out` and never while `rst_out` is still high.
- R8: In mode 1 with the request enabled, an input pulse shorter than one clock period still produces the full sequence. `rst_req` rises, `rst_out` is high for exactly one cycle starting at the second edge, and `rst_req` stays high until `rst_out` falls.
- R9: In mode 2, an input pulse that begins and ends between two rising edges has no effect: both outputs stay 0.
- R10: In mode 1, if the merged condition returns during the two-edge release window, `rst_out` stays high without any gap.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock of the domain that receives the reset |
| rst_in | input | N_RST | Reset sources; the polarity of each bit is set by LOW_MASK |
| rst_out | output | 1 | Conditioned reset, active-high |
| rst_req | output | 1 | Early reset request, active-high, leads `rst_out` |

## Verification
Faults in the two-stage chain show at the ports within two or three edges. A stuck first stage holds `rst_out` high past the second edge after release, or never raises it. A wrong arm or hold flop makes `rst_out` rise on the first edge, which destroys the lead time. It can also let `rst_req` fall a cycle early after a short pulse, or leave a one-cycle hole in the request. Polarity errors show at once as a reset that is asserted from an idle input. Each of these is caught on the first edge at which the sequence departs from the expected edge count.

// File: rtl/rst_bridge.sv
module rst_bridge #(
  parameter int N_RST = 3,
  parameter logic [N_RST-1:0] LOW_MASK = '0,
  parameter int MODE = 1,
  parameter bit REQ_EN = 1'b1
) (
  input  logic             clk,
  input  logic [N_RST-1:0] rst_in,
  output logic             rst_out,
  output logic             rst_req
);

  logic hit;
  assign hit = |(rst_in ^ LOW_MASK);

  generate
    if (MODE == 0) begin : g_pass
      assign rst_out = hit;
      assign rst_req = hit;
    end else begin : g_sync
      logic s0_q, s1_q;
      logic [2:0] warm_q;

      always_ff @(posedge clk) warm_q <= {warm_q[1:0], 1'b1};

      if (MODE == 1) begin : g_async
        always_ff @(posedge clk or posedge hit) begin
          if (hit) begin
            s0_q <= 1'b1;
            s1_q <= 1'b1;
          end else begin
            s0_q <= 1'b0;
            s1_q <= s0_q;
          end
        end

        // R1 R3 R4
        hit_seen_chk: assert property (@(posedge clk) disable iff (!warm_q[2])
          hit |-> (rst_req || rst_out));
      end else begin : g_clocked
        always_ff @(posedge clk) begin
          s0_q <= hit;
          s1_q <= s0_q;
        end

        // R5
        hit_seen_chk: assert property (@(posedge clk) disable iff (!warm_q[2])
          $past(hit, 2) |-> (rst_req || rst_out));
      end

      // R6
      release_gap_chk: assert property (@(posedge clk) disable iff (!warm_q[2])
        $fell(rst_out) |-> $past(!hit, 2));

      if (REQ_EN) begin : g_req
        logic arm_q, hold_q;

        always_ff @(posedge clk) begin
          arm_q  <= s1_q & ~hold_q;
          hold_q <= hold_q ? s0_q : arm_q;
        end

        assign rst_out = hold_q;
        assign rst_req = s1_q | arm_q | hold_q;

        // R4 R5
        lead_time_chk: assert property (@(posedge clk) disable iff (!warm_q[2])
          $rose(rst_out) |-> ($past(rst_req) && $past(rst_req, 2)));

        // R7 R8
        req_order_chk: assert property (@(posedge clk) disable iff (!warm_q[2])
          $fell(rst_req) |-> (!rst_out && $past(rst_out)));
      end else begin : g_noreq
        assign rst_out = s1_q;
        assign rst_req = 1'b0;
      end
    end
  endgenerate

endmodule

// File: tb/test_rst_bridge.sv
module test_rst_bridge;

  localparam logic [2:0] IDLE = 3'b010;

  logic       clk = 1'b0;
  logic [2:0] rst_in = 3'b101;
  logic a_rst, a_req, n_rst, n_req, c_rst, c_req, p_rst, p_req;
  int checks = 0;
  int fails = 0;
  bit done = 1'b0;

  always #10 clk = ~clk;

  rst_bridge #(.N_RST(3), .LOW_MASK(IDLE), .MODE(1), .REQ_EN(1'b1)) i_rst_bridge (
    .clk(clk), .rst_in(rst_in), .rst_out(a_rst), .rst_req(a_req));
  rst_bridge #(.N_RST(3), .LOW_MASK(IDLE), .MODE(1), .REQ_EN(1'b0)) i_rst_bridge_noreq (
    .clk(clk), .rst_in(rst_in), .rst_out(n_rst), .rst_req(n_req));
  rst_bridge #(.N_RST(3), .LOW_MASK(IDLE), .MODE(2), .REQ_EN(1'b1)) i_rst_bridge_clk (
    .clk(clk), .rst_in(rst_in), .rst_out(c_rst), .rst_req(c_req));
  rst_bridge #(.N_RST(3), .LOW_MASK(IDLE), .MODE(0), .REQ_EN(1'b1)) i_rst_bridge_pass (
    .clk(clk), .rst_in(rst_in), .rst_out(p_rst), .rst_req(p_req));

  task automatic chk(input string tag, input logic got, input logic exp);
    checks++;
    if (got !== exp) begin
      fails++;
      $display("FAIL %s got=%b exp=%b at %0t", tag, got, exp, $time);
    end
  endtask

  task automatic nedge();
    @(negedge clk);
  endtask

  task automatic t_power();
    repeat (6) nedge();
    chk("R4 reset state a_rst", a_rst, 1'b1);
    chk("R4 reset state a_req", a_req, 1'b1);
    chk("R3 reset state n_rst", n_rst, 1'b1);
    chk("R3 reset state n_req", n_req, 1'b0);
    chk("R5 reset state c_rst", c_rst, 1'b1);
    chk("R2 reset state p_rst", p_rst, 1'b1);
  endtask

  task automatic t_release();
    nedge();
    rst_in = IDLE;
    #1;
    chk("R2 pass release rst", p_rst, 1'b0);
    chk("R2 pass release req", p_req, 1'b0);
    chk("R6 a_rst held after release", a_rst, 1'b1);
    nedge();
    chk("R6 a_rst edge1", a_rst, 1'b1);
    chk("R7 a_req edge1", a_req, 1'b1);
    chk("R6 n_rst edge1", n_rst, 1'b1);
    chk("R6 c_rst edge1", c_rst, 1'b1);
    chk("R7 c_req edge1", c_req, 1'b1);
    nedge();
    chk("R6 a_rst edge2", a_rst, 1'b0);
    chk("R7 a_req edge2", a_req, 1'b0);
    chk("R6 n_rst edge2", n_rst, 1'b0);
    chk("R3 n_req low", n_req, 1'b0);
    chk("R6 c_rst edge2", c_rst, 1'b0);
    chk("R7 c_req edge2", c_req, 1'b0);
  endtask

  task automatic t_assert(input int idx);
    nedge();
    rst_in = IDLE ^ (3'b001 << idx);
    #1;
    chk($sformatf("R1 R2 input %0d pass rst", idx), p_rst, 1'b1);
    chk($sformatf("R2 input %0d pass req", idx), p_req, 1'b1);
    chk($sformatf("R4 input %0d a_req immediate", idx), a_req, 1'b1);
    chk($sformatf("R4 input %0d a_rst waits", idx), a_rst, 1'b0);
    chk($sformatf("R3 input %0d n_rst immediate", idx), n_rst, 1'b1);
    chk($sformatf("R5 input %0d c_req waits", idx), c_req, 1'b0);
    nedge();
    chk("R4 a_rst low after edge1", a_rst, 1'b0);
    chk("R4 a_req high after edge1", a_req, 1'b1);
    chk("R5 c_req low after edge1", c_req, 1'b0);
    nedge();
    chk("R4 a_rst high after edge2", a_rst, 1'b1);
    chk("R5 c_req high after edge2", c_req, 1'b1);
    chk("R5 c_rst low after edge2", c_rst, 1'b0);
    nedge();
    chk("R5 c_rst low after edge3", c_rst, 1'b0);
    nedge();
    chk("R5 c_rst high after edge4", c_rst, 1'b1);
    chk("R5 c_req high after edge4", c_req, 1'b1);
    t_release();
  endtask

  task automatic t_short_pulse();
    nedge();
    rst_in = IDLE ^ 3'b001;
    #3;
    rst_in = IDLE;
    #1;
    chk("R8 a_req latched", a_req, 1'b1);
    chk("R8 a_rst not yet", a_rst, 1'b0);
    nedge();
    chk("R8 a_req edge1", a_req, 1'b1);
    chk("R8 a_rst edge1", a_rst, 1'b0);
    chk("R9 c_req ignores pulse edge1", c_req, 1'b0);
    chk("R9 c_rst ignores pulse edge1", c_rst, 1'b0);
    nedge();
    chk("R8 a_rst edge2", a_rst, 1'b1);
    chk("R8 a_req edge2", a_req, 1'b1);
    chk("R9 c_req ignores pulse edge2", c_req, 1'b0);
    nedge();
    chk("R8 a_rst edge3", a_rst, 1'b0);
    chk("R8 a_req edge3", a_req, 1'b0);
    chk("R9 c_rst ignores pulse edge3", c_rst, 1'b0);
    chk("R9 c_req ignores pulse edge3", c_req, 1'b0);
  endtask

  task automatic t_clk_pulse();
    nedge();
    rst_in = IDLE ^ 3'b100;
    nedge();
    rst_in = IDLE;
    nedge();
    chk("R5 pulse c_req edge2", c_req, 1'b1);
    chk("R5 pulse c_rst edge2", c_rst, 1'b0);
    nedge();
    chk("R5 pulse c_req edge3", c_req, 1'b1);
    chk("R5 pulse c_rst edge3", c_rst, 1'b0);
    nedge();
    chk("R5 pulse c_rst edge4", c_rst, 1'b1);
    nedge();
    chk("R7 pulse c_rst edge5", c_rst, 1'b0);
    chk("R7 pulse c_req edge5", c_req, 1'b0);
    repeat (3) nedge();
  endtask

  task automatic t_reassert();
    nedge();
    rst_in = IDLE ^ 3'b010;
    repeat (4) nedge();
    chk("R10 a_rst active", a_rst, 1'b1);
    nedge();
    rst_in = IDLE;
    nedge();
    chk("R10 a_rst in window", a_rst, 1'b1);
    rst_in = IDLE ^ 3'b010;
    #1;
    chk("R10 a_req on return", a_req, 1'b1);
    nedge();
    chk("R10 a_rst edge2", a_rst, 1'b1);
    nedge();
    chk("R10 a_rst edge3", a_rst, 1'b1);
    repeat (3) nedge();
    t_release();
    repeat (3) nedge();
  endtask

  initial begin
    t_power();
    t_release();
    for (int i = 0; i < 3; i++) t_assert(i);
    t_short_pulse();
    t_clk_pulse();
    t_reassert();
    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    #2000000;
    if (!done) begin
      checks++;
      fails++;
      $display("FAIL watchdog got=running exp=finished");
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

endmodule